// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for a four-beat burst into a synchronous memory. A starting address is captured from the external address bus when either of two active-low load strobes is accepted. After that, the lowest two bits walk through the burst each time an active-low advance input allows a step. The upper bits stay latched for the whole burst, so a burst never leaves its four-word aligned block.

Two load strobes are provided. The processor strobe loads whenever its qualifier from the chip-enable logic is valid. The controller strobe loads only while the processor strobe is inactive. On the edge where the processor strobe is taken, the advance input has no effect. A static mode input picks the beat order. When it is high, the order is interleaved: the start bits are XORed with a beat count. When it is low, the order is linear: the start bits plus the beat count, wrapping modulo four.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge where procStrobeN is 0 and procAccept is 1, curAddr takes the value of extAddr after that edge, and the beat count restarts at 0.
- R2: On a rising edge where ctrlStrobeN is 0, ctrlAccept is 1 and procStrobeN is 1, curAddr takes the value of extAddr and the beat count restarts at 0. If procStrobeN is 0 on that edge, the controller strobe has no effect.
- R3: A strobe that is low while its own qualifier is 0 loads nothing and does not step. curAddr is unchanged after that edge, even if advanceN is 0.
- R4: With interleaveSel = 1, curAddr[1:0] equals the start bits XOR the beat count. The beat count runs 0, 1, 2, 3.
- R5: With interleaveSel = 0, curAddr[1:0] equals the start bits plus the beat count, modulo 4 (start 01 gives 01, 10, 11, 00).
- R6: On an edge that accepts the processor strobe, advanceN is ignored. The first beat is the start address even when advanceN is 0.
- R7: The beat count steps by one only on an edge where advanceN is 0 and both procStrobeN and ctrlStrobeN are 1. If advanceN is 1 with both strobes high, curAddr is held.
- R8: Bits above bit 1 never change except on a load. After the fourth beat, a further step wraps the beat count to 0 and curAddr returns to the start address.
- R9: While rst_n is 0 at a rising edge, curAddr becomes 0 and the beat count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| extAddr | input | ADDR_W | External starting address |
| procStrobeN | input | 1 | Processor load strobe, active low |
| ctrlStrobeN | input | 1 | Controller load strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| procAccept | input | 1 | Chip-enable qualifier for the processor strobe |
| ctrlAccept | input | 1 | Chip-enable qualifier for the controller strobe |
| interleaveSel | input | 1 | 1 selects interleaved order, 0 selects linear order |
| curAddr | output | ADDR_W | Current burst address |

## Verification
The bench loads with advanceN already low on the processor strobe edge. A design that honours advance there would present the second beat first. The bench also drives each strobe low with its qualifier cleared while advanceN is low; a design that treats a rejected strobe as idle would step when it should hold. Both orders are run past the fourth beat. A design that carries into bit 2 instead of wrapping, or that builds the linear order with XOR, shows the wrong address on that wrap beat. A controller strobe that arrives while the processor strobe is low but unqualified must leave the address alone, which catches a priority mistake between the two strobes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } seqStrobes_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        procStrobeN,
  input  logic        ctrlStrobeN,
  input  logic        advanceN,
  input  logic        procAccept,
  input  logic        ctrlAccept,
  output seqStrobes_t strobes
);
  logic procTake;
  logic ctrlTake;

  always_comb begin
    procTake     = !procStrobeN && procAccept;
    ctrlTake     = procStrobeN && !ctrlStrobeN && ctrlAccept;
    strobes.load = procTake || ctrlTake;
    strobes.step = procStrobeN && ctrlStrobeN && !advanceN;
  end

  // R6: an edge with the processor strobe low never advances the burst
  assert_no_step_on_proc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !procStrobeN |-> !strobes.step);

  // R3: a rejected controller strobe neither loads nor steps
  assert_reject_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (procStrobeN && !ctrlStrobeN && !ctrlAccept) |-> !(strobes.load || strobes.step));
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobes_t       strobes,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              interleaveSel,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (strobes.load) begin
      baseAddr <= extAddr;
      beatCnt  <= '0;
    end else if (strobes.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  always_comb begin
    if (interleaveSel) lowBits = baseAddr[BEAT_W-1:0] ^ beatCnt;
    else               lowBits = baseAddr[BEAT_W-1:0] + beatCnt;
    curAddr = {baseAddr[ADDR_W-1:BEAT_W], lowBits};
  end

  // R1: a load presents the captured address with the beat count cleared
  assert_load_captures_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (curAddr == $past(extAddr)) && (beatCnt == '0));

  // R8: the upper bits only move on a load
  assert_upper_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.load |=> $stable(curAddr[ADDR_W-1:BEAT_W]));

  // R7: a step advances the beat count by one, wrapping
  assert_step_advances_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.step && !strobes.load) |=> beatCnt == BEAT_W'($past(beatCnt) + 1'b1));

  // R7: no load and no step holds the address while the mode is steady
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.load && !strobes.step) |=> ($stable(interleaveSel) -> $stable(curAddr)));

  logic [UPPER_W-1:0] unusedUpper;
  assign unusedUpper = '0;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              procAccept,
  input  logic              ctrlAccept,
  input  logic              interleaveSel,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int BEAT_W = 2;

  seqStrobes_t strobes;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .procAccept(procAccept), .ctrlAccept(ctrlAccept),
    .strobes(strobes)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .extAddr(extAddr),
    .interleaveSel(interleaveSel), .curAddr(curAddr)
  );
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] extAddr;
  logic          procStrobeN, ctrlStrobeN, advanceN, procAccept, ctrlAccept, interleaveSel;
  logic [AW-1:0] curAddr;

  int checks = 0;
  int fails  = 0;
  int refBase = 0;
  int refBeat = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .extAddr(extAddr), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .procAccept(procAccept),
    .ctrlAccept(ctrlAccept), .interleaveSel(interleaveSel), .curAddr(curAddr)
  );

  function automatic int expAddr();
    int lo;
    if (interleaveSel) lo = (refBase & 3) ^ refBeat;
    else               lo = ((refBase & 3) + refBeat) % 4;
    return (refBase & ~3) | lo;
  endfunction

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic cycle(input logic r, input int a, input logic p, input logic c,
                       input logic adv, input logic pa, input logic ca, input string tag);
    rst_n = r; extAddr = AW'(a); procStrobeN = p; ctrlStrobeN = c;
    advanceN = adv; procAccept = pa; ctrlAccept = ca;
    @(posedge clk);
    if (!r) begin refBase = 0; refBeat = 0; end
    else if (!p && pa) begin refBase = a & ((1 << AW) - 1); refBeat = 0; end
    else if (p && !c && ca) begin refBase = a & ((1 << AW) - 1); refBeat = 0; end
    else if (p && c && !adv) refBeat = (refBeat + 1) % 4;
    @(negedge clk);
    checks++;
    if (int'(curAddr) != expAddr()) begin
      fails++;
      $display("FAIL %s: curAddr=%h expected=%h", tag, curAddr, AW'(expAddr()));
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    interleaveSel = 1'b1;
    @(negedge clk);
    cycle(0, 'h1FFFF, 0, 0, 0, 1, 1, "R9");
    cycle(0, 'h0, 1, 1, 1, 0, 0, "R9");
    // interleaved burst, start low bits 10, advance low on load edge
    cycle(1, 'h1ABC6, 0, 1, 0, 1, 0, "R6");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R4");
    cycle(1, 'h0, 1, 1, 1, 0, 0, "R7");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R4");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R4");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R8");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R8");
    // rejected strobes hold
    cycle(1, 'h05555, 0, 1, 0, 0, 1, "R3");
    cycle(1, 'h05555, 1, 0, 0, 0, 0, "R3");
    // controller strobe blocked while processor strobe low
    cycle(1, 'h07777, 0, 0, 0, 0, 1, "R2");
    // linear order, controller load, start 01
    interleaveSel = 1'b0;
    cycle(1, 'h0F0F1, 1, 0, 0, 0, 1, "R2");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R5");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R5");
    cycle(1, 'h0, 1, 1, 1, 1, 1, "R7");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R5");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R8");
    // linear load via processor strobe, start 11
    cycle(1, 'h12343, 0, 0, 0, 1, 1, "R1");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R5");
    cycle(1, 'h0, 1, 1, 0, 0, 0, "R5");
    // mixed stimulus per mode
    seed = 12345;
    for (int m = 0; m < 2; m++) begin
      interleaveSel = m[0];
      cycle(1, 'h0A5A2, 0, 1, 1, 1, 0, "R1");
      for (int i = 0; i < 200; i++) begin
        seed = seed * 1103515245 + 12345;
        cycle(1, (seed >>> 8) & 'h1FFFF, (seed >>> 3) % 4 != 0, (seed >>> 5) % 4 != 0,
              seed[20], seed[21], seed[22], "R7");
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule